// File: doc/BRIEF.md
# Trilinear Color Line Realignment Buffer

This block sits behind the digitizers of a three-color linear scanning sensor. Each color row is built as two staggered sub-rows, A and B, and each sub-row holds half of the pixels of a full-resolution line. The rows lie at fixed distances in scan lines. Blue, green and red are spaced by a color gap. The two sub-rows of one color are spaced by a smaller sub-row gap. As a result, the six sample streams that arrive in the same input beat belong to different physical lines of the page. The block writes every stream into an on-chip line store. It reads each stream back a fixed number of lines later, so that all six samples of one page line come out together.

Each input beat carries one sample per color and sub-row, together with a valid strobe, a line-start marker and the scan direction. The direction picks which end of the row stack sees the page first. The block turns each beat into two consecutive RGB output pixels: pixel 2j from sub-row A, then pixel 2j+1 from sub-row B. The output carries a line-start marker and a flag for the first fully aligned line. The output stays silent until the longest delay holds real data.

The controller has three states. ST_PRIME means the alignment window is still filling. ST_WAIT means it is aligned and waiting for a beat. ST_HOLD means the sub-row B pixel of the last beat is pending. The transitions are as follows:
- ST_PRIME goes to ST_HOLD on the first aligned beat.
- ST_WAIT goes to ST_HOLD on an aligned beat.
- ST_WAIT goes back to ST_PRIME on a restart.
- ST_HOLD always goes to ST_WAIT on the next cycle.

A restart is the first line start after reset, or a line start whose direction differs from that of the previous line. The depth of the store is parameterized: pixels per sub-row (HALF_PIX), color gap (COLOR_GAP), sub-row gap (SUB_GAP) and sample width (SAMPLE_W). The longest delay is MAXD = 2*COLOR_GAP + SUB_GAP lines.

Top module: `rl_realign`

## Requirements
- R1: After reset, out_valid, out_sol and out_first are low, and they stay low until an aligned beat arrives.
- R2: With in_dir = 0, the streams are delayed by these numbers of lines:
  - red A: SUB_GAP; red B: 0
  - green A: COLOR_GAP + SUB_GAP; green B: COLOR_GAP
  - blue A: 2*COLOR_GAP + SUB_GAP; blue B: 2*COLOR_GAP
- R3: An accepted beat produces two output pixels on consecutive cycles. The first (even index 2j) takes the three sub-row A samples; the second (index 2j+1) takes the three sub-row B samples. The red, green and blue samples of each pixel go to out_r, out_g and out_b. Beats must be separated by at least one idle cycle.
- R4: Line numbering restarts at 0 on each restart. The beats of lines 0 to MAXD-1 produce no output. Lines MAXD and later are output.
- R5: out_first is high on every pixel of line MAXD, the first aligned line after a restart, and low on all other pixels.
- R6: out_sol is high only on output pixel 0 of a line.
- R7: With in_dir = 1, the streams are delayed by these numbers of lines:
  - red B: 2*COLOR_GAP + SUB_GAP; red A: 2*COLOR_GAP
  - green B: COLOR_GAP + SUB_GAP; green A: COLOR_GAP
  - blue B: SUB_GAP; blue A: 0
- R8: A line start whose in_dir differs from that of the previous line restarts the count. Output is then withheld for another MAXD lines.
- R9: The sub-row A pixel of a beat appears one cycle after the beat. The sub-row B pixel appears on the cycle after that.
- R10: in_dir is sampled only on beats that carry in_sol. A change of in_dir on other beats does not affect the delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat strobe |
| in_sol | input | 1 | Beat is the first of a line |
| in_dir | input | 1 | Scan direction, sampled at line start |
| in_r_a | input | SAMPLE_W | Red sub-row A sample |
| in_r_b | input | SAMPLE_W | Red sub-row B sample |
| in_g_a | input | SAMPLE_W | Green sub-row A sample |
| in_g_b | input | SAMPLE_W | Green sub-row B sample |
| in_b_a | input | SAMPLE_W | Blue sub-row A sample |
| in_b_b | input | SAMPLE_W | Blue sub-row B sample |
| out_valid | output | 1 | Output pixel strobe |
| out_sol | output | 1 | Output pixel 0 of a line |
| out_first | output | 1 | Pixel belongs to the first aligned line |
| out_r | output | SAMPLE_W | Aligned red sample |
| out_g | output | SAMPLE_W | Aligned green sample |
| out_b | output | SAMPLE_W | Aligned blue sample |

## Verification
The bench builds the block with HALF_PIX = 4, COLOR_GAP = 3, SUB_GAP = 1 and SAMPLE_W = 12. This gives MAXD = 7 and a ring of 8 line slots, so both the fill window and several wraps of the slot pointer fit into a few hundred cycles. Every sample carries its color, a line tag and its full-line pixel index. The bench chooses each stream's tag so that, once the stream has been delayed by its required amount, all three colors of an output pixel carry the same tag. The run covers both directions. It includes a restart caused by a direction change and a mid-line toggle of in_dir.

// File: rtl/rl_pkg.sv
package rl_pkg;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HOLD  = 2'd2
    } rl_state_e;

    // color index: 0 red, 1 green, 2 blue; sub: 0 = A, 1 = B
    // rev = 0: blue row meets the page first and sub-row A leads
    // rev = 1: red row meets the page first and sub-row B leads
    function automatic int stream_delay(int color, int sub, bit rev, int cg, int sg);
        int base;
        int lead;
        base = rev ? (2 - color) * cg : color * cg;
        lead = rev ? 1 : 0;
        return base + ((sub == lead) ? sg : 0);
    endfunction

endpackage

// File: rtl/rl_line_store.sv
module rl_line_store #(
    parameter int W    = 12,
    parameter int HALF = 8,
    parameter int NL   = 35,
    parameter int SW   = $clog2(NL),
    parameter int PW   = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] wslot,
    input  logic [PW-1:0] wpix,
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] rslot,
    input  logic          bypass,
    output logic [W-1:0]  dout
);
    localparam int DEPTH = NL * HALF;
    localparam int AW    = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    assign waddr = AW'(wslot) * AW'(HALF) + AW'(wpix);
    assign raddr = AW'(rslot) * AW'(HALF) + AW'(wpix);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= din;
    end

    // a zero-delay stream takes the live sample, older slots come from the store
    assign dout = bypass ? din : mem[raddr];

endmodule

// File: rtl/rl_line_track.sv
module rl_line_track #(
    parameter int HALF = 8,
    parameter int NL   = 35,
    parameter int MAXD = 34,
    parameter int SW   = $clog2(NL),
    parameter int PW   = (HALF > 1) ? $clog2(HALF) : 1,
    parameter int CW   = $clog2(MAXD + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic          in_dir,
    output logic          accept,
    output logic          restart,
    output logic [SW-1:0] cur_slot,
    output logic [PW-1:0] cur_pix,
    output logic          cur_dir,
    output logic [CW-1:0] cur_cnt
);
    localparam logic [SW-1:0] SLOT_LAST = SW'(NL - 1);
    localparam logic [PW-1:0] PIX_LAST  = PW'(HALF - 1);
    localparam logic [CW-1:0] CNT_SAT   = CW'(MAXD + 1);

    logic          started_q;
    logic          dir_q;
    logic [SW-1:0] slot_q;
    logic [PW-1:0] pix_q;
    logic [CW-1:0] cnt_q;
    logic          line_start;

    assign accept     = in_valid && (started_q || in_sol);
    assign line_start = accept && in_sol;
    assign restart    = line_start && (!started_q || (in_dir != dir_q));
    assign cur_dir    = line_start ? in_dir : dir_q;
    assign cur_slot   = line_start ? ((slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1) : slot_q;
    assign cur_pix    = line_start ? '0 : pix_q;

    always_comb begin
        if (restart)         cur_cnt = '0;
        else if (line_start) cur_cnt = (cnt_q == CNT_SAT) ? CNT_SAT : cnt_q + 1'b1;
        else                 cur_cnt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            dir_q     <= 1'b0;
            slot_q    <= '0;
            pix_q     <= '0;
            cnt_q     <= '0;
        end else if (accept) begin
            started_q <= 1'b1;
            dir_q     <= cur_dir;
            slot_q    <= cur_slot;
            pix_q     <= (cur_pix == PIX_LAST) ? '0 : cur_pix + 1'b1;
            cnt_q     <= cur_cnt;
        end
    end

    // R10
    dir_mid_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_sol) |=> (dir_q == $past(dir_q)));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_SAT);

endmodule

// File: rtl/rl_realign.sv
module rl_realign #(
    parameter int SAMPLE_W  = 12,
    parameter int HALF_PIX  = 8,
    parameter int COLOR_GAP = 16,
    parameter int SUB_GAP   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sol,
    input  logic                in_dir,
    input  logic [SAMPLE_W-1:0] in_r_a,
    input  logic [SAMPLE_W-1:0] in_r_b,
    input  logic [SAMPLE_W-1:0] in_g_a,
    input  logic [SAMPLE_W-1:0] in_g_b,
    input  logic [SAMPLE_W-1:0] in_b_a,
    input  logic [SAMPLE_W-1:0] in_b_b,
    output logic                out_valid,
    output logic                out_sol,
    output logic                out_first,
    output logic [SAMPLE_W-1:0] out_r,
    output logic [SAMPLE_W-1:0] out_g,
    output logic [SAMPLE_W-1:0] out_b
);
    import rl_pkg::*;

    localparam int MAXD    = 2 * COLOR_GAP + SUB_GAP;
    localparam int NL      = MAXD + 1;
    localparam int SW      = $clog2(NL);
    localparam int PW      = (HALF_PIX > 1) ? $clog2(HALF_PIX) : 1;
    localparam int CW      = $clog2(MAXD + 2);
    localparam int NSTREAM = 6;
    localparam logic [SW:0]   NL_W    = (SW + 1)'(NL);
    localparam logic [CW-1:0] MAXD_CW = CW'(MAXD);

    logic          accept;
    logic          restart;
    logic [SW-1:0] cur_slot;
    logic [PW-1:0] cur_pix;
    logic          cur_dir;
    logic [CW-1:0] cur_cnt;
    logic          aligned;

    logic [SAMPLE_W-1:0] din  [NSTREAM];
    logic [SAMPLE_W-1:0] dout [NSTREAM];

    assign din[0] = in_r_a;
    assign din[1] = in_r_b;
    assign din[2] = in_g_a;
    assign din[3] = in_g_b;
    assign din[4] = in_b_a;
    assign din[5] = in_b_b;

    rl_line_track #(
        .HALF(HALF_PIX), .NL(NL), .MAXD(MAXD), .SW(SW), .PW(PW), .CW(CW)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_dir(in_dir), .accept(accept), .restart(restart),
        .cur_slot(cur_slot), .cur_pix(cur_pix), .cur_dir(cur_dir),
        .cur_cnt(cur_cnt)
    );

    for (genvar gi = 0; gi < NSTREAM; gi++) begin : g_stream
        localparam int D_FWD = stream_delay(gi / 2, gi % 2, 1'b0, COLOR_GAP, SUB_GAP);
        localparam int D_REV = stream_delay(gi / 2, gi % 2, 1'b1, COLOR_GAP, SUB_GAP);
        localparam logic [SW:0] BACK_FWD = (SW + 1)'(NL - D_FWD);
        localparam logic [SW:0] BACK_REV = (SW + 1)'(NL - D_REV);

        logic [SW:0]   rsum;
        logic [SW-1:0] rslot;
        logic          bypass;

        assign rsum   = {1'b0, cur_slot} + (cur_dir ? BACK_REV : BACK_FWD);
        assign rslot  = (rsum >= NL_W) ? SW'(rsum - NL_W) : SW'(rsum);
        assign bypass = cur_dir ? (D_REV == 0) : (D_FWD == 0);

        rl_line_store #(
            .W(SAMPLE_W), .HALF(HALF_PIX), .NL(NL), .SW(SW), .PW(PW)
        ) u_store (
            .clk(clk), .we(accept), .wslot(cur_slot), .wpix(cur_pix),
            .din(din[gi]), .rslot(rslot), .bypass(bypass), .dout(dout[gi])
        );
    end

    assign aligned = accept && (cur_cnt >= MAXD_CW);

    rl_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PRIME: if (aligned) st_d = ST_HOLD;
            ST_WAIT: begin
                if (restart)      st_d = ST_PRIME;
                else if (aligned) st_d = ST_HOLD;
            end
            ST_HOLD:  st_d = ST_WAIT;
            default:  st_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_PRIME;
        else        st_q <= st_d;
    end

    logic [SAMPLE_W-1:0] hold_r, hold_g, hold_b;
    logic                hold_first;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sol    <= 1'b0;
            out_first  <= 1'b0;
            out_r      <= '0;
            out_g      <= '0;
            out_b      <= '0;
            hold_r     <= '0;
            hold_g     <= '0;
            hold_b     <= '0;
            hold_first <= 1'b0;
        end else if (st_q == ST_HOLD) begin
            out_valid <= 1'b1;
            out_sol   <= 1'b0;
            out_first <= hold_first;
            out_r     <= hold_r;
            out_g     <= hold_g;
            out_b     <= hold_b;
        end else begin
            out_valid  <= aligned;
            out_sol    <= aligned && (cur_pix == '0);
            out_first  <= aligned && (cur_cnt == MAXD_CW);
            out_r      <= dout[0];
            out_g      <= dout[2];
            out_b      <= dout[4];
            hold_r     <= dout[1];
            hold_g     <= dout[3];
            hold_b     <= dout[5];
            hold_first <= (cur_cnt == MAXD_CW);
        end
    end

    // R3
    beat_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |-> !in_valid);

    // R9
    second_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> out_valid);

    // R4
    prime_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRIME) |-> !out_valid);

    // R6
    sol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sol) |=> (out_valid && !out_sol));

    // R5
    first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_first || out_sol) |-> out_valid);

endmodule

// File: tb/rl_realign_bench.sv
`timescale 1ns/1ps
module rl_realign_bench;
    localparam int W    = 12;
    localparam int HALF = 4;
    localparam int CG   = 3;
    localparam int SG   = 1;
    localparam int MAXD = 2 * CG + SG;

    typedef struct {
        logic [W-1:0] r;
        logic [W-1:0] g;
        logic [W-1:0] b;
        logic         sol;
        logic         first;
        logic         second;
        string        req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sol = 1'b0, in_dir = 1'b0;
    logic [W-1:0] in_r_a = '0, in_r_b = '0, in_g_a = '0, in_g_b = '0, in_b_a = '0, in_b_b = '0;
    logic out_valid, out_sol, out_first;
    logic [W-1:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];
    logic prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    rl_realign #(.SAMPLE_W(W), .HALF_PIX(HALF), .COLOR_GAP(CG), .SUB_GAP(SG)) u_rl_realign (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_dir(in_dir),
        .in_r_a(in_r_a), .in_r_b(in_r_b), .in_g_a(in_g_a), .in_g_b(in_g_b),
        .in_b_a(in_b_a), .in_b_b(in_b_b),
        .out_valid(out_valid), .out_sol(out_sol), .out_first(out_first),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // delay table of R2 (dir 0) and R7 (dir 1); color 0 R, 1 G, 2 B; sub 0 A, 1 B
    function automatic int req_delay(int color, int sub, bit dir);
        int base;
        if (!dir) base = color * CG + ((sub == 0) ? SG : 0);
        else      base = (2 - color) * CG + ((sub == 1) ? SG : 0);
        return base;
    endfunction

    // sample layout: [11:10] color, [9:4] line tag, [3:0] full-line pixel index
    function automatic logic [W-1:0] mk(int color, int tag, int k);
        return {2'(color), 6'(tag), 4'(k)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one line of beats; t = line number since the last restart
    task automatic drive_line(input int t, input bit dir, input bit toggle_mid, input string req);
        for (int j = 0; j < HALF; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sol   = (j == 0);
            in_dir   = (toggle_mid && j == 2) ? !dir : dir;
            in_r_a = mk(0, t + req_delay(0, 0, dir), 2 * j);
            in_r_b = mk(0, t + req_delay(0, 1, dir), 2 * j + 1);
            in_g_a = mk(1, t + req_delay(1, 0, dir), 2 * j);
            in_g_b = mk(1, t + req_delay(1, 1, dir), 2 * j + 1);
            in_b_a = mk(2, t + req_delay(2, 0, dir), 2 * j);
            in_b_b = mk(2, t + req_delay(2, 1, dir), 2 * j + 1);
            if (t >= MAXD) begin
                for (int s = 0; s < 2; s++) begin
                    exp_t e;
                    e.r = mk(0, t, 2 * j + s);
                    e.g = mk(1, t, 2 * j + s);
                    e.b = mk(2, t, 2 * j + s);
                    e.sol = (j == 0 && s == 0);
                    e.first = (t == MAXD);
                    e.second = (s == 1);
                    e.req = req;
                    sb.push_back(e);
                end
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_sol   = 1'b0;
            in_dir   = dir;
        end
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", "output while window filling", 64'(out_r), 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({out_r, out_g, out_b} == {e.r, e.g, e.b}, e.req, "aligned RGB",
                          64'({out_r, out_g, out_b}), 64'({e.r, e.g, e.b}));
                    check(out_sol == e.sol, "R6", "out_sol", 64'(out_sol), 64'(e.sol));
                    check(out_first == e.first, "R5", "out_first", 64'(out_first), 64'(e.first));
                    if (e.second)
                        check(prev_valid, "R9", "sub-row B pixel follows A pixel",
                              64'(prev_valid), 64'h1);
                    else
                        check(out_r[3:0] % 2 == 0, "R3", "A pixel even index",
                              64'(out_r[3:0]), 64'(e.r[3:0]));
                end
            end
            prev_valid <= out_valid;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
        check(out_sol == 1'b0 && out_first == 1'b0, "R1", "markers after reset",
              64'({out_sol, out_first}), 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "idle after reset", 64'(out_valid), 64'h0);

        // R2, R4, R5: forward direction fill and alignment; R10: mid-line toggle on line 9
        for (int t = 0; t < MAXD + 6; t++)
            drive_line(t, 1'b0, (t == 9), (t == 9) ? "R10" : "R2");
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "forward lines all emitted", 64'(sb.size()), 64'h0);

        // R8: direction change restarts the window; R7: reverse delays
        for (int t = 0; t < MAXD + 4; t++)
            drive_line(t, 1'b1, 1'b0, (t == MAXD) ? "R8" : "R7");
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7", "reverse lines all emitted", 64'(sb.size()), 64'h0);
        check(out_valid == 1'b0, "R3", "quiet after last pixel", 64'(out_valid), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule